// File: doc/BRIEF.md
# Configurable Programmable-Logic Macrocell

This block models one macrocell of a sum-of-products programmable logic device. A static configuration sets its behaviour, and software does not change it while the cell runs. An AND plane builds product terms from a parameterized vector of array inputs. Each input can be taken in true form, in complement form, or in both. Eight of the terms are ORed into the cell's sum.

The sum either goes straight to the pin, for combinational use, or passes through a storage element. That element can be set to behave as a D, T, JK or SR flip-flop. Two further product terms have fixed jobs:
- The first clears the register asynchronously.
- The second is either the pin's output enable or a clock built in the logic array.

A feedback selector sends back either the cell output or the pin value. The selected signals leave the block on two ports: a local one for neighbours in the same group and a global one for the whole device. The parent routes them back into the array inputs of this cell and of others.

All masks and modes are static inputs. The register's own clock comes either from the global `clk` or from the control product term.

Top module: `plm_cell`

## Requirements
- R1: Product term t uses mask bits [t*N_IN +: N_IN] of `cfg_true` and `cfg_comp`. A set bit i in `cfg_true` adds `arr_in[i]` to the AND, and a set bit in `cfg_comp` adds its complement. Terms 0..7 are ORed into the sum. With `cfg_registered`=0, `pin_out` equals that sum with no clock edge needed.
- R2: A term with no literal selected evaluates to 1. A term that selects both the true and the complement form of the same input evaluates to 0.
- R3: With `cfg_registered`=1 and `cfg_ff`=0 (D), the register loads the sum on each rising edge of its clock, and `pin_out` shows the register.
- R4: With `cfg_ff`=1 (T), the register inverts when the sum is 1 at the clock edge and holds when it is 0.
- R5: With `cfg_ff`=2 (JK), J is the OR of terms 0..3 and K is the OR of terms 4..7. J alone sets the register, K alone clears it, both together invert it, and neither holds it.
- R6: With `cfg_ff`=3 (SR), S is the OR of terms 0..3 and R is the OR of terms 4..7. S alone sets the register and R alone clears it. Both active, or neither, holds it.
- R7: While term 8 (clear) is 1, or `rst_n` is 0, the register is 0 at once with no clock edge needed. It stays 0 across any clock edge that arrives while the clear is active.
- R8: With `cfg_ctrl_clk`=0, `pin_oe` follows term 9 and the register is clocked by `clk` only.
- R9: With `cfg_ctrl_clk`=1, the register is clocked by rising edges of term 9 and edges of `clk` have no effect. `pin_oe` is held at 1.
- R10: With `cfg_fb`=0 (cell), both `fb_local_o` and `fb_global_o` carry the cell output. With `cfg_fb`=1 (pin), both carry `pin_in`.
- R11: With `cfg_fb`=2 (dual), `fb_local_o` carries the cell output. While `cfg_pin_unused`=0, `fb_global_o` carries `pin_in`. While `cfg_pin_unused`=1, `pin_oe` is forced to 1 and `fb_global_o` carries the driven `pin_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Global clock for the register when the control term is not used as clock |
| rst_n | input | 1 | Active-low reset, clears the register asynchronously |
| arr_in | input | N_IN | Array inputs: dedicated inputs and routed feedback |
| pin_in | input | 1 | Value seen at the I/O pin when it is not driven |
| cfg_true | input | (N_SUM+2)*N_IN | Per-term include mask for true literals |
| cfg_comp | input | (N_SUM+2)*N_IN | Per-term include mask for complement literals |
| cfg_registered | input | 1 | 1 = registered output, 0 = combinational output |
| cfg_ff | input | 2 | Flip-flop type: 0 D, 1 T, 2 JK, 3 SR |
| cfg_ctrl_clk | input | 1 | 1 = term 9 is the register clock, 0 = term 9 is the output enable |
| cfg_fb | input | 2 | Feedback mode: 0 cell, 1 pin, 2 dual |
| cfg_pin_unused | input | 1 | In dual mode, the pin carries no outside signal |
| pin_out | output | 1 | Cell output toward the pin driver |
| pin_oe | output | 1 | Pin driver enable |
| fb_local_o | output | 1 | Feedback for cells of the same group |
| fb_global_o | output | 1 | Feedback for all cells of the device |

## Verification
The asynchronous clear and a register clock edge can fall in the same cycle. The bench loads a 1 into a D register, raises the clear input between edges, and holds it across the next `clk` edge while the sum is still 1. The check is that `pin_out` drops before the edge and stays 0 after it, then returns to 1 on the first edge after the clear is released. A second overlap is tested in output-enable mode: the control term toggles between two edges while the D input changes. `pin_oe` must follow the term, while the register must wait for the `clk` edge.

// File: rtl/plm_pkg.sv
package plm_pkg;

   typedef enum logic [1:0] {
      FF_D  = 2'd0,
      FF_T  = 2'd1,
      FF_JK = 2'd2,
      FF_SR = 2'd3
   } ff_mode_e;

   typedef enum logic [1:0] {
      FB_CELL = 2'd0,
      FB_PIN  = 2'd1,
      FB_DUAL = 2'd2,
      FB_RSVD = 2'd3
   } fb_mode_e;

   // Next register value for every flip-flop personality.
   // s: full sum, a/b: lower and upper half sums.
   function automatic logic ff_next(ff_mode_e m, logic q, logic s, logic a, logic b);
      logic n;
      unique case (m)
         FF_D:  n = s;
         FF_T:  n = q ^ s;
         FF_JK: begin
            unique case ({a, b})
               2'b10:   n = 1'b1;
               2'b01:   n = 1'b0;
               2'b11:   n = ~q;
               default: n = q;
            endcase
         end
         default: begin
            if (a && !b)      n = 1'b1;
            else if (b && !a) n = 1'b0;
            else              n = q;
         end
      endcase
      return n;
   endfunction

endpackage

// File: rtl/plm_term_array.sv
module plm_term_array #(
   parameter int N_IN    = 6,
   parameter int N_TERMS = 10,
   localparam int MW     = N_TERMS * N_IN
) (
   input  logic [N_IN-1:0]    arr_in,
   input  logic [MW-1:0]      mask_t,
   input  logic [MW-1:0]      mask_c,
   output logic [N_TERMS-1:0] terms
);

   for (genvar t = 0; t < N_TERMS; t++) begin : g_term
      logic [N_IN-1:0] mt;
      logic [N_IN-1:0] mc;
      assign mt = mask_t[t*N_IN +: N_IN];
      assign mc = mask_c[t*N_IN +: N_IN];
      // An unselected literal contributes a 1, so an empty term is 1.
      assign terms[t] = (&(~mt | arr_in)) & (&(~mc | ~arr_in));
   end

endmodule

// File: rtl/plm_sum_split.sv
module plm_sum_split #(
   parameter int N_SUM = 8,
   localparam int HALF = N_SUM / 2
) (
   input  logic [N_SUM-1:0] terms,
   output logic             sum_all,
   output logic             sum_lo,
   output logic             sum_hi
);

   if (N_SUM < 2 || (N_SUM % 2) != 0) begin : g_bad_sum
      $error("plm_sum_split: N_SUM must be even and at least 2");
   end

   assign sum_lo  = |terms[HALF-1:0];
   assign sum_hi  = |terms[N_SUM-1:HALF];
   assign sum_all = sum_lo | sum_hi;

endmodule

// File: rtl/plm_flop.sv
module plm_flop
   import plm_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     clr_term,
   input  logic     ctrl_term,
   input  logic     ctrl_is_clk,
   input  ff_mode_e mode,
   input  logic     sum_all,
   input  logic     sum_lo,
   input  logic     sum_hi,
   output logic     q
);

   logic reg_clk;
   logic clr_a;
   logic q_nxt;

   assign reg_clk = ctrl_is_clk ? ctrl_term : clk;
   assign clr_a   = clr_term | ~rst_n;
   assign q_nxt   = ff_next(mode, q, sum_all, sum_lo, sum_hi);

   always_ff @(posedge reg_clk or posedge clr_a) begin
      if (clr_a) q <= 1'b0;
      else       q <= q_nxt;
   end

endmodule

// File: rtl/plm_fb_sel.sv
module plm_fb_sel
   import plm_pkg::*;
(
   input  logic     cell_out,
   input  logic     oe_raw,
   input  logic     pin_in,
   input  fb_mode_e mode,
   input  logic     pin_unused,
   output logic     pin_oe,
   output logic     fb_local,
   output logic     fb_global
);

   logic pad;

   always_comb begin
      pin_oe = oe_raw;
      if (mode == FB_DUAL && pin_unused) pin_oe = 1'b1;
   end

   // Value present at the pad: driven cell output, else outside signal.
   assign pad = pin_oe ? cell_out : pin_in;

   always_comb begin
      unique case (mode)
         FB_PIN: begin
            fb_local  = pin_in;
            fb_global = pin_in;
         end
         FB_DUAL: begin
            fb_local  = cell_out;
            fb_global = pin_unused ? pad : pin_in;
         end
         default: begin
            fb_local  = cell_out;
            fb_global = cell_out;
         end
      endcase
   end

endmodule

// File: rtl/plm_cell.sv
module plm_cell
   import plm_pkg::*;
#(
   parameter int N_IN  = 6,
   parameter int N_SUM = 8,
   localparam int N_TERMS = N_SUM + 2,
   localparam int MW      = N_TERMS * N_IN,
   localparam int IDX_CLR = N_SUM,
   localparam int IDX_CTL = N_SUM + 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N_IN-1:0] arr_in,
   input  logic            pin_in,
   input  logic [MW-1:0]   cfg_true,
   input  logic [MW-1:0]   cfg_comp,
   input  logic            cfg_registered,
   input  logic [1:0]      cfg_ff,
   input  logic            cfg_ctrl_clk,
   input  logic [1:0]      cfg_fb,
   input  logic            cfg_pin_unused,
   output logic            pin_out,
   output logic            pin_oe,
   output logic            fb_local_o,
   output logic            fb_global_o
);

   if (N_IN < 1) begin : g_bad_in
      $error("plm_cell: N_IN must be at least 1");
   end

   logic [N_TERMS-1:0] terms;
   logic               sum_all;
   logic               sum_lo;
   logic               sum_hi;
   logic               clr_term;
   logic               ctrl_term;
   logic               reg_q;
   logic               oe_raw;

   plm_term_array #(.N_IN(N_IN), .N_TERMS(N_TERMS)) u_array (
      .arr_in (arr_in),
      .mask_t (cfg_true),
      .mask_c (cfg_comp),
      .terms  (terms)
   );

   plm_sum_split #(.N_SUM(N_SUM)) u_sum (
      .terms   (terms[N_SUM-1:0]),
      .sum_all (sum_all),
      .sum_lo  (sum_lo),
      .sum_hi  (sum_hi)
   );

   assign clr_term  = terms[IDX_CLR];
   assign ctrl_term = terms[IDX_CTL];

   plm_flop u_flop (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr_term    (clr_term),
      .ctrl_term   (ctrl_term),
      .ctrl_is_clk (cfg_ctrl_clk),
      .mode        (ff_mode_e'(cfg_ff)),
      .sum_all     (sum_all),
      .sum_lo      (sum_lo),
      .sum_hi      (sum_hi),
      .q           (reg_q)
   );

   assign pin_out = cfg_registered ? reg_q : sum_all;
   assign oe_raw  = cfg_ctrl_clk ? 1'b1 : ctrl_term;

   plm_fb_sel u_fb (
      .cell_out   (pin_out),
      .oe_raw     (oe_raw),
      .pin_in     (pin_in),
      .mode       (fb_mode_e'(cfg_fb)),
      .pin_unused (cfg_pin_unused),
      .pin_oe     (pin_oe),
      .fb_local   (fb_local_o),
      .fb_global  (fb_global_o)
   );

endmodule

// File: rtl/plm_cell_chk.sv
module plm_cell_chk #(
   parameter int N_IN  = 6,
   parameter int N_SUM = 8,
   localparam int MW   = (N_SUM + 2) * N_IN
) (
   input logic          clk,
   input logic          rst_n,
   input logic [MW-1:0] cfg_true,
   input logic [MW-1:0] cfg_comp,
   input logic          cfg_registered,
   input logic [1:0]    cfg_ff,
   input logic          cfg_ctrl_clk,
   input logic [1:0]    cfg_fb,
   input logic          cfg_pin_unused,
   input logic          reg_q,
   input logic          sum_all,
   input logic          clr_term,
   input logic          pin_out,
   input logic          pin_oe,
   input logic          fb_global_o
);

   logic [6:0] mode_bits;
   assign mode_bits = {cfg_registered, cfg_ff, cfg_ctrl_clk, cfg_fb, cfg_pin_unused};

   // R3
   d_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_registered && cfg_ff == 2'd0 && !cfg_ctrl_clk && !clr_term)
      |=> (!$stable(mode_bits) || !$stable(cfg_true) || !$stable(cfg_comp)
           || clr_term || reg_q == $past(sum_all)));

   // R4
   t_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_registered && cfg_ff == 2'd1 && !cfg_ctrl_clk && !clr_term && sum_all)
      |=> (!$stable(mode_bits) || !$stable(cfg_true) || !$stable(cfg_comp)
           || clr_term || reg_q != $past(reg_q)));

   // R7
   clr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_term |-> (reg_q == 1'b0));

   // R9
   clk_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_ctrl_clk |-> pin_oe);

   // R11
   dual_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_fb == 2'd2 && cfg_pin_unused) |-> (pin_oe && fb_global_o == pin_out));

endmodule

bind plm_cell plm_cell_chk #(.N_IN(N_IN), .N_SUM(N_SUM)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .cfg_true       (cfg_true),
   .cfg_comp       (cfg_comp),
   .cfg_registered (cfg_registered),
   .cfg_ff         (cfg_ff),
   .cfg_ctrl_clk   (cfg_ctrl_clk),
   .cfg_fb         (cfg_fb),
   .cfg_pin_unused (cfg_pin_unused),
   .reg_q          (reg_q),
   .sum_all        (sum_all),
   .clr_term       (clr_term),
   .pin_out        (pin_out),
   .pin_oe         (pin_oe),
   .fb_global_o    (fb_global_o)
);

// File: tb/test_plm_cell.sv
module test_plm_cell;

   localparam int N_IN  = 6;
   localparam int N_SUM = 8;
   localparam int NT    = N_SUM + 2;
   localparam int MW    = NT * N_IN;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [N_IN-1:0] ai = '0;
   logic            pin_in = 1'b0;
   logic [MW-1:0]   mt = '0;
   logic [MW-1:0]   mc = '0;
   logic            c_reg = 1'b1;
   logic [1:0]      c_ff = 2'd0;
   logic            c_aclk = 1'b0;
   logic [1:0]      c_fb = 2'd0;
   logic            c_unused = 1'b0;
   logic            pin_out;
   logic            pin_oe;
   logic            fb_loc;
   logic            fb_glb;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   plm_cell #(.N_IN(N_IN), .N_SUM(N_SUM)) i_plm_cell (
      .clk            (clk),
      .rst_n          (rst_n),
      .arr_in         (ai),
      .pin_in         (pin_in),
      .cfg_true       (mt),
      .cfg_comp       (mc),
      .cfg_registered (c_reg),
      .cfg_ff         (c_ff),
      .cfg_ctrl_clk   (c_aclk),
      .cfg_fb         (c_fb),
      .cfg_pin_unused (c_unused),
      .pin_out        (pin_out),
      .pin_oe         (pin_oe),
      .fb_local_o     (fb_loc),
      .fb_global_o    (fb_glb)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic term(input int t, input logic [N_IN-1:0] tm, input logic [N_IN-1:0] cm);
      mt[t*N_IN +: N_IN] = tm;
      mc[t*N_IN +: N_IN] = cm;
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   // Sum terms disabled (both polarities of input 0), clear = in5, control term empty.
   task automatic defaults();
      for (int t = 0; t < N_SUM; t++) term(t, 6'b000001, 6'b000001);
      term(N_SUM, 6'b100000, 6'b000000);
      term(N_SUM + 1, 6'b000000, 6'b000000);
      ai = '0; pin_in = 1'b0;
      c_reg = 1'b1; c_ff = 2'd0; c_aclk = 1'b0; c_fb = 2'd0; c_unused = 1'b0;
   endtask

   task automatic clear_reg();
      ai[5] = 1'b1;
      step();
      ai[5] = 1'b0;
   endtask

   task automatic t_reset();
      defaults();
      term(0, 6'b0, 6'b0);
      rst_n = 1'b0;
      repeat (3) step();
      chk("R7 reset holds register at 0", pin_out, 1'b0);
      rst_n = 1'b1;
      step();
      chk("R3 first load after reset", pin_out, 1'b1);
   endtask

   task automatic t_comb();
      defaults();
      c_reg = 1'b0;
      term(0, 6'b000011, 6'b000000);
      term(1, 6'b000000, 6'b000100);
      for (int p = 0; p < 8; p++) begin
         ai[2:0] = p[2:0];
         #1;
         chk("R1 comb sum (a0&a1)|~a2", pin_out, (ai[0] & ai[1]) | ~ai[2]);
      end
      ai[2:0] = 3'b100;
      #1;
      chk("R2 both-polarity terms give 0", pin_out, 1'b0);
      term(3, 6'b0, 6'b0);
      #1;
      chk("R2 empty term gives 1", pin_out, 1'b1);
   endtask

   task automatic t_dff();
      defaults();
      term(0, 6'b000011, 6'b000000);
      clear_reg();
      chk("R3 cleared start", pin_out, 1'b0);
      ai[1:0] = 2'b11;
      #1;
      chk("R3 no change before edge", pin_out, 1'b0);
      step();
      chk("R3 load 1", pin_out, 1'b1);
      ai[1:0] = 2'b01;
      step();
      chk("R3 load 0", pin_out, 1'b0);
   endtask

   task automatic t_tff();
      defaults();
      c_ff = 2'd1;
      term(0, 6'b000001, 6'b000000);
      clear_reg();
      ai[0] = 1'b1;
      step();
      chk("R4 toggle to 1", pin_out, 1'b1);
      step();
      chk("R4 toggle to 0", pin_out, 1'b0);
      step();
      ai[0] = 1'b0;
      step();
      step();
      chk("R4 hold 1", pin_out, 1'b1);
   endtask

   task automatic t_jk();
      defaults();
      c_ff = 2'd2;
      term(0, 6'b000001, 6'b000000);
      term(4, 6'b000010, 6'b000000);
      clear_reg();
      ai[1:0] = 2'b01; step(); chk("R5 J sets", pin_out, 1'b1);
      ai[1:0] = 2'b00; step(); chk("R5 hold", pin_out, 1'b1);
      ai[1:0] = 2'b10; step(); chk("R5 K clears", pin_out, 1'b0);
      ai[1:0] = 2'b11; step(); chk("R5 JK toggle up", pin_out, 1'b1);
      step();                  chk("R5 JK toggle down", pin_out, 1'b0);
   endtask

   task automatic t_sr();
      defaults();
      c_ff = 2'd3;
      term(0, 6'b000001, 6'b000000);
      term(4, 6'b000010, 6'b000000);
      clear_reg();
      ai[1:0] = 2'b01; step(); chk("R6 S sets", pin_out, 1'b1);
      ai[1:0] = 2'b11; step(); chk("R6 both hold 1", pin_out, 1'b1);
      ai[1:0] = 2'b10; step(); chk("R6 R clears", pin_out, 1'b0);
      ai[1:0] = 2'b11; step(); chk("R6 both hold 0", pin_out, 1'b0);
   endtask

   task automatic t_clear();
      defaults();
      term(0, 6'b0, 6'b0);
      clear_reg();
      step();
      chk("R7 preload 1", pin_out, 1'b1);
      ai[5] = 1'b1;
      #1;
      chk("R7 async clear without edge", pin_out, 1'b0);
      #0.5;
      step();
      chk("R7 clear beats clock edge", pin_out, 1'b0);
      ai[5] = 1'b0;
      #1;
      chk("R7 stays 0 until edge", pin_out, 1'b0);
      step();
      chk("R7 reload after release", pin_out, 1'b1);
   endtask

   task automatic t_oe();
      defaults();
      term(0, 6'b000001, 6'b000000);
      term(N_SUM + 1, 6'b010000, 6'b000000);
      clear_reg();
      ai[4] = 1'b0;
      #1;
      chk("R8 oe low", pin_oe, 1'b0);
      step();
      ai[4] = 1'b1;
      #1;
      chk("R8 oe high", pin_oe, 1'b1);
      step();
      ai[0] = 1'b1;
      ai[4] = 1'b0;
      #1;
      ai[4] = 1'b1;
      #0.5;
      chk("R8 control term does not clock", pin_out, 1'b0);
      step();
      chk("R8 clk loads register", pin_out, 1'b1);
   endtask

   task automatic t_aclk();
      defaults();
      c_aclk = 1'b1;
      term(0, 6'b000001, 6'b000000);
      term(N_SUM + 1, 6'b010000, 6'b000000);
      clear_reg();
      #1;
      chk("R9 oe held 1", pin_oe, 1'b1);
      ai[0] = 1'b1;
      step();
      step();
      chk("R9 clk ignored", pin_out, 1'b0);
      ai[4] = 1'b1;
      #1;
      chk("R9 array clock loads", pin_out, 1'b1);
      ai[0] = 1'b0;
      step();
      chk("R9 clk still ignored", pin_out, 1'b1);
      ai[4] = 1'b0;
      #1;
      chk("R9 falling edge ignored", pin_out, 1'b1);
      ai[4] = 1'b1;
      #1;
      chk("R9 second array clock loads 0", pin_out, 1'b0);
      step();
      defaults();
      clear_reg();
   endtask

   task automatic t_fb();
      defaults();
      c_reg = 1'b0;
      term(0, 6'b000001, 6'b000000);
      term(N_SUM + 1, 6'b010000, 6'b000000);
      c_fb = 2'd0; ai[0] = 1'b1; pin_in = 1'b0;
      #1;
      chk("R10 cell mode local", fb_loc, 1'b1);
      chk("R10 cell mode global", fb_glb, 1'b1);
      c_fb = 2'd1; ai[0] = 1'b0; pin_in = 1'b1;
      #1;
      chk("R10 pin mode local", fb_loc, 1'b1);
      chk("R10 pin mode global", fb_glb, 1'b1);
      c_fb = 2'd2; ai[4] = 1'b0; ai[0] = 1'b1; pin_in = 1'b0;
      #1;
      chk("R11 dual local is cell", fb_loc, 1'b1);
      chk("R11 dual global is pin", fb_glb, 1'b0);
      chk("R11 dual used keeps oe", pin_oe, 1'b0);
      c_unused = 1'b1;
      #1;
      chk("R11 unused forces oe", pin_oe, 1'b1);
      chk("R11 unused global via driver", fb_glb, 1'b1);
      ai[0] = 1'b0; pin_in = 1'b1;
      #1;
      chk("R11 unused global ignores pin", fb_glb, 1'b0);
   endtask

   initial begin
      defaults();
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      #1;
      t_reset();
      t_comb();
      t_dff();
      t_tff();
      t_jk();
      t_sr();
      t_clear();
      t_oe();
      t_aclk();
      t_fb();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule